// File: doc/BRIEF.md
# Continuous-Phase Two-Tone FSK Synthesizer

This block turns a serial transmit bit into a square wave whose frequency shifts between two tones without any phase jump. A 12-bit phase register advances by one of two fixed steps on every clock: a larger step while the data bit is one and a smaller one while it is zero. The register's top bit is the square wave. That wave drives the enable of the output current stage. With the default steps the mean step is 256 out of 4096, so the centre tone is one sixteenth of the clock. The two tones sit at plus and minus 13/4096 of the clock around that centre.

The data bit is used as it stands in each cycle. It is not resampled or filtered, so whatever feeds the bit alone sets the bit rate. A separate 3-bit level code selects one of six output current levels. It is decoded to a one-hot level vector. The two highest codes are reserved: they mute the wave and raise an error flag. When transmission is disabled, the phase register is cleared and the wave is held low.

Top module: `fsk_phase_synth`

## Requirements
- R1: While reset `rst_n` is low, the phase register is zero and `drive` is low. After reset, the first enabled cycle starts from phase zero.
- R2: On each clock edge with `tx_en` high and `tx_bit` = 1, the phase register advances by 269, modulo 4096.
- R3: On each clock edge with `tx_en` high and `tx_bit` = 0, the phase register advances by 243, modulo 4096. The register wraps past 4095 without saturating.
- R4: `drive` equals bit 11 of the phase register whenever `tx_en` is high and the level code is 0 to 5.
- R5: A change of `tx_bit` never clears or reloads the phase register. Phase carries straight across bit boundaries.
- R6: A clock edge with `tx_en` low clears the phase register to zero. `drive` is low in any cycle in which `tx_en` is low.
- R7: Level code k, for k from 0 to 5, sets bit k of `lvl_onehot` and no other bit. The codes, from 0 to 5, stand for 1.8, 3.5, 7.5, 30, 60 and 110 mA.
- R8: Level codes 6 and 7 raise `lvl_err`, clear `lvl_onehot` and force `drive` low. The phase register keeps advancing, so the wave resumes in phase once a valid code returns.
- R9: With a constant data bit held for 4096 enabled cycles from phase zero, `drive` is high in exactly 2048 of them and the phase returns to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Synthesis clock (PLL-derived) |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmit enable; low clears phase and mutes output |
| tx_bit | input | 1 | Serial data bit selecting the tone |
| lvl_code | input | 3 | Output current level code |
| drive | output | 1 | Square-wave enable for the output current stage |
| lvl_onehot | output | 6 | One-hot decoded current level |
| lvl_err | output | 1 | Reserved level code present |

## Verification
The phase step for a data bit and the muting of the output can land in the same cycle. This happens when a reserved level code or a drop of `tx_en` coincides with a bit change, or with the top phase bit being high. Random stimulus changes the bit, the enable and the level code independently on every cycle, so these cases occur often. Each cycle, `drive` is compared with a bench phase model stepped from the requirements. A muted cycle must read low while the model keeps its phase, and the next unmuted cycle must match the model again.

// File: rtl/fsk_phase_synth.sv
module fsk_phase_synth #(
  parameter int ACC_W    = 12,
  parameter int STEP_MID = 256,
  parameter int STEP_DEV = 13,
  parameter int LVL_W    = 3,
  parameter int N_LVL    = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_en,
  input  logic             tx_bit,
  input  logic [LVL_W-1:0] lvl_code,
  output logic             drive,
  output logic [N_LVL-1:0] lvl_onehot,
  output logic             lvl_err
);

  localparam logic [ACC_W-1:0] STEP_HI = ACC_W'(STEP_MID + STEP_DEV);
  localparam logic [ACC_W-1:0] STEP_LO = ACC_W'(STEP_MID - STEP_DEV);

  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] step;

  assign step = tx_bit ? STEP_HI : STEP_LO;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc <= '0;
    else if (!tx_en) acc <= '0;
    else             acc <= acc + step;
  end

  assign lvl_err = (int'(lvl_code) >= N_LVL);

  for (genvar k = 0; k < N_LVL; k++) begin : g_lvl
    assign lvl_onehot[k] = (int'(lvl_code) == k);
  end

  assign drive = acc[ACC_W-1] & tx_en & ~lvl_err;

endmodule

module fsk_phase_synth_chk #(
  parameter int ACC_W    = 12,
  parameter int STEP_MID = 256,
  parameter int STEP_DEV = 13,
  parameter int LVL_W    = 3,
  parameter int N_LVL    = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tx_en,
  input logic             tx_bit,
  input logic [LVL_W-1:0] lvl_code,
  input logic             drive,
  input logic [N_LVL-1:0] lvl_onehot,
  input logic             lvl_err,
  input logic [ACC_W-1:0] acc
);
  localparam logic [ACC_W-1:0] UP = ACC_W'(STEP_MID + STEP_DEV);
  localparam logic [ACC_W-1:0] DN = ACC_W'(STEP_MID - STEP_DEV);

  logic armed;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;

  // R1
  reset_zero_chk: assert property (@(posedge clk) !rst_n |-> acc == '0 && !drive);

  // R2
  step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(tx_en) && $past(tx_bit) |-> ACC_W'(acc - $past(acc)) == UP);

  // R3
  step_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(tx_en) && !$past(tx_bit) |-> ACC_W'(acc - $past(acc)) == DN);

  // R6
  idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !$past(tx_en) |-> acc == '0);

  // R6
  idle_mute_chk: assert property (@(posedge clk) disable iff (!rst_n) !tx_en |-> !drive);

  // R7
  level_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lvl_onehot) && (lvl_err || $countones(lvl_onehot) == 1));

  // R8
  reserved_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_err |-> lvl_onehot == '0 && !drive);
endmodule

bind fsk_phase_synth fsk_phase_synth_chk #(
  .ACC_W(ACC_W), .STEP_MID(STEP_MID), .STEP_DEV(STEP_DEV), .LVL_W(LVL_W), .N_LVL(N_LVL)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tx_bit(tx_bit), .lvl_code(lvl_code),
  .drive(drive), .lvl_onehot(lvl_onehot), .lvl_err(lvl_err), .acc(acc)
);

// File: tb/fsk_phase_synth_test.sv
`timescale 1ns/1ps
module fsk_phase_synth_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_en = 1'b0;
  logic       tx_bit = 1'b0;
  logic [2:0] lvl_code = 3'd0;
  logic       drive;
  logic [5:0] lvl_onehot;
  logic       lvl_err;

  int checks = 0;
  int errors = 0;
  logic [11:0] m_acc = 12'd0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fsk_phase_synth uut (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tx_bit(tx_bit),
    .lvl_code(lvl_code), .drive(drive), .lvl_onehot(lvl_onehot), .lvl_err(lvl_err)
  );

  function automatic logic exp_drive(logic [11:0] a, logic en, logic [2:0] c);
    return a[11] & en & (c < 3'd6);
  endfunction

  function automatic logic [5:0] exp_onehot(logic [2:0] c);
    return (c < 3'd6) ? 6'(1) << c : 6'd0;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // one cycle: apply at negedge, model steps at posedge, compare at next negedge
  task automatic step(logic en, logic b, logic [2:0] c, string req);
    tx_en = en; tx_bit = b; lvl_code = c;
    @(posedge clk);
    if (!en) m_acc = 12'd0;
    else     m_acc = m_acc + (b ? 12'd269 : 12'd243);
    @(negedge clk);
    check(req, {31'd0, drive}, {31'd0, exp_drive(m_acc, en, c)});
    check("R7", {26'd0, lvl_onehot}, {26'd0, exp_onehot(c)});
    check("R8", {31'd0, lvl_err}, {31'd0, (c >= 3'd6)});
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int highs;
    void'($urandom(32'd20240611));
    tx_en = 1'b1; tx_bit = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", {31'd0, drive}, 32'd0);
    rst_n = 1'b1;
    m_acc = 12'd0;
    // R2: ones from zero; first high lands after 8 steps (8*269=2152)
    for (int i = 0; i < 20; i++) step(1'b1, 1'b1, 3'd5, "R2");
    // R6: disable clears phase and mutes
    step(1'b0, 1'b1, 3'd2, "R6");
    step(1'b0, 1'b0, 3'd2, "R6");
    // R3: zeros from zero, wraps past 4095
    for (int i = 0; i < 40; i++) step(1'b1, 1'b0, 3'd1, "R3");
    // R5: alternating bits each cycle, phase continues
    for (int i = 0; i < 60; i++) step(1'b1, i[0], 3'd3, "R5");
    // R7: sweep every code
    for (int c = 0; c < 8; c++) step(1'b1, 1'b1, 3'(c), "R7");
    // R8: reserved code while phase runs, then resume in phase
    for (int i = 0; i < 24; i++) step(1'b1, i[2], 3'd6 + 3'(i[0]), "R8");
    for (int i = 0; i < 16; i++) step(1'b1, 1'b0, 3'd4, "R8");
    // R9: full period with constant bit, both tones
    for (int b = 0; b < 2; b++) begin
      step(1'b0, 1'b0, 3'd0, "R6");
      highs = 0;
      for (int i = 0; i < 4096; i++) begin
        step(1'b1, b[0], 3'd0, "R4");
        highs += drive;
      end
      check("R9", highs, 2048);
      check("R9", {20'd0, m_acc}, 32'd0);
    end
    // R4: random mix of bit, enable and level code
    for (int i = 0; i < 4000; i++) begin
      logic en, b;
      logic [2:0] c;
      en = ($urandom % 16) != 0;
      b  = ($urandom % 4) == 0 ? ~tx_bit : tx_bit;
      c  = ($urandom % 8 == 0) ? 3'(6 + $urandom % 2) : 3'($urandom % 6);
      step(en, b, c, "R4");
    end
    // R1: reset mid-run returns to phase zero
    tx_en = 1'b1;
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", {31'd0, drive}, 32'd0);
    rst_n = 1'b1;
    m_acc = 12'd0;
    for (int i = 0; i < 12; i++) step(1'b1, 1'b1, 3'd0, "R1");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule